// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level radix page table held in memory. It is started after a translation-buffer miss. A request carries the virtual address and an access kind (instruction fetch, data load or data store). The root table's page number comes from the translation control register and is sampled when the request is accepted.

The walker reads one 32-bit page table entry per level through a simple memory port. It decodes each entry and either descends to the next table, stops at a leaf, or stops with a page fault. When it stops at a permitted leaf, it returns the physical address, the leaf's eight flag bits and a page-size shift that is always 12. Large pages are not formed: a leaf found in the upper table is still handled as a 4 KiB page. Fault causes are reported apart from one another: invalid entry, missing leaf, and one permission code for each access kind.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `fault` and `mem_req_valid` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the walk has reported, and a `req_valid` seen while it is low starts no walk and changes no result.
- R3: The first entry is read at byte address (`root_ppn` << 12) + 4 × vaddr[31:22]. After the walker descends, the second entry is read at (entry PPN << 12) + 4 × vaddr[21:12], where the entry PPN is entry bits [31:10].
- R4: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. The walker waits any number of cycles for `mem_rsp_valid`.
- R5: An entry with V (bit 0) clear, or with R (bit 1) clear and W (bit 2) set, ends the walk with `fault_code` 1, and no further entry is read.
- R6: An entry with R, W and X (bit 3) all clear is a pointer. In the upper table the walker descends to the lower table. In the lower table the walk ends with `fault_code` 2.
- R7: At a leaf, `req_acc` 0 (fetch) needs R and X, 1 (load) needs R, 2 (store) needs W, and 3 is handled as a load. A missing permission ends the walk with `fault_code` 3, 4 or 5 for fetch, load or store.
- R8: A permitted leaf raises `done` with `fault_code` 0, `paddr` = {entry PPN, vaddr[11:0]}, `pte_flags` = entry bits [7:0] (software bits [9:8] excluded) and `page_shift` = 12.
- R9: A leaf in the upper table completes after a single entry read, with `paddr` formed from the full 22-bit entry PPN and the 12-bit offset, exactly as for a lower-table leaf.
- R10: `done` and `fault` are never high together and each lasts exactly one cycle. `paddr`, `pte_flags` and `fault_code` keep their values until the next walk reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| root_ppn | input | 22 | Root table page number from the translation control register |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: page fault |
| fault_code | output | 3 | 0 none, 1 invalid, 2 no leaf, 3 fetch, 4 load, 5 store |
| paddr | output | 34 | Physical address |
| pte_flags | output | 8 | Flag bits of the leaf entry |
| page_shift | output | 5 | Page size as a shift, always 12 |

## Verification
Some rules are checked on every cycle by the assertions: a request is not taken while busy, the read request stays held with a stable address under backpressure, the completion pulses are short and never overlap, the fault code agrees with the pulse that carries it, and results stay unchanged while the walker is idle. Other matters can only be shown by the directed scenarios. These include the entry addresses at each level, the choice between descending, stopping at a leaf and faulting, the permission rule for each access kind, the formed physical address and flags, the single-read upper-level leaf, and the number of reads each walk makes.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes 32-bit entries with the flag layout V,R,W,X in bits 0..3.
package ptw_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_NO_LEAF = 3'd2,
        FLT_FETCH   = 3'd3,
        FLT_LOAD    = 3'd4,
        FLT_STORE   = 3'd5
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_RESP
    } st_e;

    typedef enum logic [1:0] {
        EV_LEAF,
        EV_DESCEND,
        EV_FAULT
    } ev_e;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int FLAG_W = 8;
endpackage

// File: rtl/ptw_pte_addr.sv
// Forms the byte address of one entry: table base page shifted to a
// byte address plus the index scaled by the entry size.
// Assumes the scaled index fits within one page.
module ptw_pte_addr #(
    parameter int PPN_W = 22,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int PTE_W = 32
) (
    input  logic [PPN_W-1:0]       base_ppn,
    input  logic [IDX_W-1:0]       idx,
    output logic [PPN_W+OFF_W-1:0] addr
);
    localparam int AW      = PPN_W + OFF_W;
    localparam int PTE_LG2 = $clog2(PTE_W / 8);

    // Base of the table plus scaled index.
    always_comb begin
        addr = {base_ppn, {OFF_W{1'b0}}} + (AW'(idx) << PTE_LG2);
    end
endmodule

// File: rtl/ptw_pte_eval.sv
// Classifies one fetched entry as leaf, pointer or fault. It applies
// the validity rule, the pointer rule (fault at the bottom level) and
// the per-access permission rule. Purely combinational.
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 22
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             at_bottom,
    input  logic [1:0]       acc,
    output ev_e              ev,
    output logic [2:0]       code,
    output logic [PPN_W-1:0] ppn
);
    logic v, r, w, x;

    assign v   = pte[BIT_V];
    assign r   = pte[BIT_R];
    assign w   = pte[BIT_W];
    assign x   = pte[BIT_X];
    assign ppn = pte[PTE_W-1 -: PPN_W];

    // Decide the outcome of this level.
    always_comb begin
        ev   = EV_FAULT;
        code = FLT_NONE;
        if (!v || (!r && w)) begin
            code = FLT_INVALID;
        end else if (!r && !w && !x) begin
            if (at_bottom) code = FLT_NO_LEAF;
            else           ev   = EV_DESCEND;
        end else begin
            case (acc)
                ACC_FETCH: if (r && x) ev = EV_LEAF; else code = FLT_FETCH;
                ACC_STORE: if (w)      ev = EV_LEAF; else code = FLT_STORE;
                default:   if (r)      ev = EV_LEAF; else code = FLT_LOAD;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. It accepts one request when idle, reads
// one entry per level over a valid/ready request, valid response port,
// and pulses done or fault for one cycle with the results held after.
// Assumes memory returns exactly one response per accepted read.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PPN_W = 22,
    parameter int PTE_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [OFF_W+2*IDX_W-1:0] req_vaddr,
    input  logic [1:0]               req_acc,
    input  logic [PPN_W-1:0]         root_ppn,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [PPN_W+OFF_W-1:0]   mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [PTE_W-1:0]         mem_rsp_data,
    output logic                     done,
    output logic                     fault,
    output logic [2:0]               fault_code,
    output logic [PPN_W+OFF_W-1:0]   paddr,
    output logic [FLAG_W-1:0]        pte_flags,
    output logic [4:0]               page_shift
);
    localparam int VA_W = OFF_W + 2 * IDX_W;
    localparam int PA_W = PPN_W + OFF_W;

    st_e               state;
    logic              lvl_q;
    logic [VA_W-1:0]   va_q;
    logic [1:0]        acc_q;
    logic [PPN_W-1:0]  base_q;
    logic [PA_W-1:0]   paddr_q;
    logic [FLAG_W-1:0] flags_q;
    logic [2:0]        code_q;
    logic              done_q, fault_q;

    logic [IDX_W-1:0]  idx;
    ev_e               ev;
    logic [2:0]        ev_code;
    logic [PPN_W-1:0]  pte_ppn;

    // Index of the current level: upper bits at level 1, middle at level 0.
    assign idx = lvl_q ? va_q[VA_W-1 -: IDX_W] : va_q[OFF_W +: IDX_W];

    ptw_pte_addr #(.PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) i_addr (
        .base_ppn (base_q),
        .idx      (idx),
        .addr     (mem_req_addr)
    );

    ptw_pte_eval #(.PTE_W(PTE_W), .PPN_W(PPN_W)) i_eval (
        .pte       (mem_rsp_data),
        .at_bottom (!lvl_q),
        .acc       (acc_q),
        .ev        (ev),
        .code      (ev_code),
        .ppn       (pte_ppn)
    );

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);
    assign done          = done_q;
    assign fault         = fault_q;
    assign fault_code    = code_q;
    assign paddr         = paddr_q;
    assign pte_flags     = flags_q;
    assign page_shift    = 5'(OFF_W);

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lvl_q   <= 1'b0;
            va_q    <= '0;
            acc_q   <= '0;
            base_q  <= '0;
            paddr_q <= '0;
            flags_q <= '0;
            code_q  <= FLT_NONE;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    acc_q  <= req_acc;
                    base_q <= root_ppn;
                    lvl_q  <= 1'b1;
                    state  <= ST_REQ;
                end
                ST_REQ: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    case (ev)
                        EV_DESCEND: begin
                            base_q <= pte_ppn;
                            lvl_q  <= 1'b0;
                            state  <= ST_REQ;
                        end
                        EV_LEAF: begin
                            paddr_q <= {pte_ppn, va_q[OFF_W-1:0]};
                            flags_q <= mem_rsp_data[FLAG_W-1:0];
                            code_q  <= FLT_NONE;
                            done_q  <= 1'b1;
                            state   <= ST_RESP;
                        end
                        default: begin
                            code_q  <= ev_code;
                            fault_q <= 1'b1;
                            state   <= ST_RESP;
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Accepted request makes the walker busy on the next cycle.
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // No memory traffic while idle.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // Read request held with a stable address under backpressure.
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // Fault always carries a nonzero cause.
    assert_fault_coded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 3'd0));

    // Success always carries a zero cause.
    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault_code == 3'd0));

    // Completion pulses never overlap.
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // Completion pulses last a single cycle.
    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));

    // Results are held while idle with no new request.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(paddr) && $stable(fault_code) && $stable(pte_flags)));
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [21:0] root_ppn = 22'h00100;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault;
    logic [2:0]  fault_code;
    logic [33:0] paddr;
    logic [7:0]  pte_flags;
    logic [4:0]  page_shift;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .root_ppn(root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_code(fault_code), .paddr(paddr), .pte_flags(pte_flags),
        .page_shift(page_shift)
    );

    // Memory model: table contents, backpressure and latency.
    logic [31:0] mem [bit [33:0]];
    bit          toggle_rdy = 0;
    int          rsp_lat = 0;
    int          hs_total = 0;
    logic [33:0] addr_log [4];
    bit          pend = 0;
    int          cnt = 0;
    logic [33:0] pend_addr = '0;

    always @(posedge clk) begin
        mem_req_ready <= toggle_rdy ? ~mem_req_ready : 1'b1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            addr_log[hs_total % 4] <= mem_req_addr;
            hs_total  <= hs_total + 1;
            pend      <= 1'b1;
            cnt       <= rsp_lat;
            pend_addr <= mem_req_addr;
        end else if (pend) begin
            if (cnt == 0) begin
                pend          <= 1'b0;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [33:0] l1_addr(input logic [31:0] va);
        return {root_ppn, 12'h0} + 34'(va[31:22]) * 4;
    endfunction

    function automatic logic [33:0] l0_addr(input logic [21:0] tppn, input logic [31:0] va);
        return {tppn, 12'h0} + 34'(va[21:12]) * 4;
    endfunction

    // Pointer in the upper table to a lower table, plus the lower entry.
    task automatic map2(input logic [31:0] va, input logic [31:0] leaf);
        logic [21:0] t = 22'h00200 + 22'(va[31:22]);
        mem[l1_addr(va)]   = {t, 2'b00, 8'h01};
        mem[l0_addr(t, va)] = leaf;
    endtask

    function automatic logic [31:0] mk_pte(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b11, fl};
    endfunction

    logic        r_done, r_fault;
    logic [2:0]  r_code;
    logic [33:0] r_pa;
    logic [7:0]  r_fl;
    int          r_reads;

    // One walk: issue, wait for a pulse, capture results, check pulse ends.
    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input string req);
        int start = hs_total;
        bit seen = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300 && !seen; i++) begin
            if (done || fault) seen = 1;
            else @(negedge clk);
        end
        chk({req, " completion seen"}, 64'(seen), 64'd1);
        r_done = done; r_fault = fault; r_code = fault_code;
        r_pa = paddr; r_fl = pte_flags; r_reads = hs_total - start;
        @(negedge clk);
        chk("R10 pulse ends", 64'(done || fault), 64'd0);
        chk("R10 result held", 64'({paddr, fault_code}), 64'({r_pa, r_code}));
    endtask

    task automatic t_reset();
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 done/fault", 64'({done, fault}), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_load_ok();
        logic [31:0] va = 32'h1234_5678;
        logic [21:0] t = 22'h00200 + 22'(va[31:22]);
        map2(va, mk_pte(22'h2ABCD, 8'hC3));
        walk(va, 2'd1, "R8");
        chk("R8 done", 64'({r_done, r_fault}), 64'b10);
        chk("R8 paddr", 64'(r_pa), 64'({22'h2ABCD, 12'h678}));
        chk("R8 flags exclude rsw", 64'(r_fl), 64'hC3);
        chk("R8 page_shift", 64'(page_shift), 64'd12);
        chk("R8 code zero", 64'(r_code), 64'd0);
        chk("R3 two reads", 64'(r_reads), 64'd2);
        chk("R3 first addr", 64'(addr_log[(hs_total - 2) % 4]), 64'(l1_addr(va)));
        chk("R3 second addr", 64'(addr_log[(hs_total - 1) % 4]), 64'(l0_addr(t, va)));
    endtask

    task automatic t_fetch();
        map2(32'h0040_1000, mk_pte(22'h00011, 8'h09));
        walk(32'h0040_1000, 2'd0, "R7");
        chk("R7 fetch without R faults 3", 64'({r_fault, r_code}), 64'({1'b1, 3'd3}));
        map2(32'h0040_2000, mk_pte(22'h00012, 8'h0B));
        walk(32'h0040_2004, 2'd0, "R7");
        chk("R7 fetch with R,X ok", 64'({r_done, r_pa}), 64'({1'b1, 22'h00012, 12'h004}));
    endtask

    task automatic t_load_perm();
        map2(32'h0080_3000, mk_pte(22'h00013, 8'h09));
        walk(32'h0080_3000, 2'd1, "R7");
        chk("R7 load without R faults 4", 64'({r_fault, r_code}), 64'({1'b1, 3'd4}));
        walk(32'h0080_3000, 2'd3, "R7");
        chk("R7 acc 3 as load faults 4", 64'({r_fault, r_code}), 64'({1'b1, 3'd4}));
    endtask

    task automatic t_store();
        map2(32'h00C0_4000, mk_pte(22'h00014, 8'h03));
        walk(32'h00C0_4000, 2'd2, "R7");
        chk("R7 store without W faults 5", 64'({r_fault, r_code}), 64'({1'b1, 3'd5}));
        map2(32'h00C0_5000, mk_pte(22'h00015, 8'h07));
        walk(32'h00C0_5FFC, 2'd2, "R7");
        chk("R7 store with W ok", 64'({r_done, r_pa}), 64'({1'b1, 22'h00015, 12'hFFC}));
    endtask

    task automatic t_invalid();
        logic [31:0] va = 32'hFFC0_0000;
        mem[l1_addr(va)] = 32'h0000_0400;
        walk(va, 2'd1, "R5");
        chk("R5 V=0 faults 1", 64'({r_fault, r_code}), 64'({1'b1, 3'd1}));
        chk("R5 one read only", 64'(r_reads), 64'd1);
        map2(32'h0100_6000, mk_pte(22'h00016, 8'h05));
        walk(32'h0100_6000, 2'd2, "R5");
        chk("R5 R=0 W=1 faults 1", 64'({r_fault, r_code}), 64'({1'b1, 3'd1}));
    endtask

    task automatic t_no_leaf();
        map2(32'h0140_7000, mk_pte(22'h00017, 8'h01));
        walk(32'h0140_7000, 2'd1, "R6");
        chk("R6 pointer at bottom faults 2", 64'({r_fault, r_code}), 64'({1'b1, 3'd2}));
        chk("R6 descended: two reads", 64'(r_reads), 64'd2);
    endtask

    task automatic t_upper_leaf();
        logic [31:0] va = 32'h0180_9ABC;
        mem[l1_addr(va)] = mk_pte(22'h3F0A5, 8'h43);
        walk(va, 2'd1, "R9");
        chk("R9 upper leaf done", 64'(r_done), 64'd1);
        chk("R9 paddr full ppn", 64'(r_pa), 64'({22'h3F0A5, 12'hABC}));
        chk("R9 single read", 64'(r_reads), 64'd1);
    endtask

    task automatic t_backpressure();
        toggle_rdy = 1; rsp_lat = 5;
        map2(32'h01C0_A000, mk_pte(22'h00020, 8'h03));
        walk(32'h01C0_A010, 2'd1, "R4");
        chk("R4 slow memory result", 64'({r_done, r_pa}), 64'({1'b1, 22'h00020, 12'h010}));
        chk("R4 reads", 64'(r_reads), 64'd2);
        toggle_rdy = 0; rsp_lat = 0;
    endtask

    task automatic t_busy();
        int start = hs_total;
        bit seen = 0;
        rsp_lat = 4;
        map2(32'h0200_B000, mk_pte(22'h00021, 8'h03));
        map2(32'h0240_C000, mk_pte(22'h00022, 8'h03));
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0200_B008; req_acc = 2'd1;
        @(negedge clk);
        req_vaddr = 32'h0240_C00C;
        chk("R2 ready low while busy", 64'(req_ready), 64'd0);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300 && !seen; i++) begin
            if (done || fault) seen = 1;
            else @(negedge clk);
        end
        chk("R2 first request result", 64'({done, paddr}), 64'({1'b1, 22'h00021, 12'h008}));
        repeat (20) @(negedge clk);
        chk("R2 no extra walk", 64'(hs_total - start), 64'd2);
        chk("R2 result unchanged", 64'(paddr), 64'({22'h00021, 12'h008}));
        rsp_lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_ok();
        t_fetch();
        t_load_perm();
        t_store();
        t_invalid();
        t_no_leaf();
        t_upper_leaf();
        t_backpressure();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule